// File: doc/BRIEF.md
# Shift-Register DAC Frame Serializer

This block feeds a resistor-ladder audio DAC that is loaded through a chain of four cascaded 8-bit serial-in, parallel-out shift registers with an output latch. Once per sample period it takes one stereo frame: a 16-bit left sample and a 16-bit right sample. It sends the 32 bits out serially on a data line and qualifies the master clock with a shift enable, so the external chain is clocked only while a valid bit is present. A single latch strobe then moves all 32 parallel outputs to the ladder at the same moment.

The whole block runs from the audio master clock. A sample period is a fixed frame of 256 master-clock cycles, which gives 44.1 kHz from 11.2896 MHz. The shift enable is active for 32 cycles, the latch strobe follows, and the chain clock then stays stopped for the remainder of the frame. The only instant the block must always hit is the latch strobe. If the upstream buffer has no frame ready at the start of a period, the last frame is sent again and a sticky underrun flag is raised. An optional mode turns each two's-complement sample into offset binary as it is loaded.

Top module: `sr_dac_framer`

## Requirements
- R1: While `rst` is high, `shift_en`, `latch_stb`, `in_ready` and `underrun` are low. After reset the stored frame is all zeros: with `ob_mode` low it is sent as 32 zero bits, and with `ob_mode` high each sample is sent as 0x8000.
- R2: `in_ready` is high for exactly one cycle in every 256, and that cycle is frame cycle 0. The first cycle after `rst` falls is frame cycle 0.
- R3: `shift_en` is high in frame cycles 1 to 32 inclusive, which is exactly 32 cycles per frame, and low in every other cycle.
- R4: `latch_stb` is high only in frame cycle 33. It therefore pulses exactly once every 256 cycles and never in the same cycle as `shift_en`.
- R5: In frame cycle c (1 to 32), `ser_data` carries bit 32-c of the loaded 32-bit word. The left sample occupies `in_frame[31:16]` and the right sample `in_frame[15:0]`, so bits go out MSB first with the left sample first. `ser_data` changes only on falling clock edges.
- R6: A frame is accepted when `in_valid` is high in frame cycle 0. The values of `in_valid`, `in_frame` and `ob_mode` in any other cycle have no effect on the bits sent.
- R7: If `in_valid` is low in frame cycle 0, the last accepted frame is sent again, or the reset frame if none has been accepted. `underrun` goes high from the next cycle and stays high until reset.
- R8: If `ob_mode` is high in frame cycle 0, the word sent in that frame has bits 31 and 15 inverted. This applies to repeated frames too, and the mode is taken separately for each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| in_frame | input | 32 | Stereo frame, left sample in [31:16], right sample in [15:0] |
| in_valid | input | 1 | A frame is offered on `in_frame` |
| in_ready | output | 1 | High in frame cycle 0; the frame is taken when `in_valid` is also high |
| ob_mode | input | 1 | Invert each sample MSB (offset binary) for the frame loaded this cycle |
| ser_data | output | 1 | Serial data to the shift-register chain, updated on falling edges |
| shift_en | output | 1 | Qualifier for the chain shift clock |
| latch_stb | output | 1 | One-cycle strobe for the chain's output latch |
| underrun | output | 1 | Sticky flag: a frame start passed with no frame offered |

## Verification
Two functions can meet in frame cycle 0. The handshake for the next frame, which either accepts a new word or repeats the old one and raises the underrun flag, falls in the same period position where the offset-binary choice is taken. A third function, the ignored input traffic of the other 255 cycles, runs all around that cycle. The bench provokes this by driving `in_valid`, `in_frame` and `ob_mode` with opposite or junk values in every cycle except frame cycle 0. In frame cycle 0 it mixes accepted and missing frames with both modes, including a repeat taken in a different mode from the one in which the frame was first sent. A cycle-by-cycle model then judges every strobe, enable and serial bit of the following frame, together with the moment the underrun flag rises.

// File: rtl/sr_dac_pkg.sv
package sr_dac_pkg;
  localparam int unsigned DEF_SAMPLE_W     = 16;
  localparam int unsigned DEF_NUM_CH       = 2;
  localparam int unsigned DEF_FRAME_CYCLES = 256;

  // Position of the master-clock counter within one sample period
  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,  // frame start: capture a frame, start the enable
    PH_SHIFT = 2'd1,  // advance the shift register
    PH_LATCH = 2'd2,  // last bit is out: schedule the latch strobe
    PH_IDLE  = 2'd3   // chain clock stopped
  } phase_t;
endpackage

// File: rtl/sr_dac_frame_timer.sv
module sr_dac_frame_timer
  import sr_dac_pkg::*;
#(
  parameter int unsigned FRAME_CYCLES = DEF_FRAME_CYCLES,
  parameter int unsigned SHIFT_BITS   = DEF_SAMPLE_W * DEF_NUM_CH
) (
  input  logic   clk,
  input  logic   rst,
  output phase_t phase
);
  localparam int unsigned CNT_W = $clog2(FRAME_CYCLES);
  localparam logic [CNT_W-1:0] POS_LAST  = CNT_W'(FRAME_CYCLES - 1);
  localparam logic [CNT_W-1:0] POS_LATCH = CNT_W'(SHIFT_BITS);

  logic [CNT_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (pos == POS_LAST) begin
      pos <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  always_comb begin
    if (pos == '0) begin
      phase = PH_LOAD;
    end else if (pos < POS_LATCH) begin
      phase = PH_SHIFT;
    end else if (pos == POS_LATCH) begin
      phase = PH_LATCH;
    end else begin
      phase = PH_IDLE;
    end
  end
endmodule

// File: rtl/sr_dac_frame_store.sv
module sr_dac_frame_store #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned NUM_CH   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       take,
  input  logic                       in_valid,
  input  logic [SAMPLE_W*NUM_CH-1:0] in_frame,
  input  logic                       ob_mode,
  output logic [SAMPLE_W*NUM_CH-1:0] load_word,
  output logic                       underrun
);
  localparam int unsigned WORD_W = SAMPLE_W * NUM_CH;

  logic [WORD_W-1:0] held;
  logic [WORD_W-1:0] raw_sel;

  assign raw_sel = in_valid ? in_frame : held;

  // Per-sample offset-binary conversion: flip the sign bit of each channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign load_word[ch*SAMPLE_W + SAMPLE_W-1] =
      raw_sel[ch*SAMPLE_W + SAMPLE_W-1] ^ ob_mode;
    assign load_word[ch*SAMPLE_W +: (SAMPLE_W-1)] =
      raw_sel[ch*SAMPLE_W +: (SAMPLE_W-1)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= '0;
      underrun <= 1'b0;
    end else if (take) begin
      if (in_valid) begin
        held <= in_frame;
      end else begin
        underrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sr_dac_shifter.sv
module sr_dac_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [WORD_W-1:0] load_word,
  output logic              ser_data
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (load) begin
      shreg <= load_word;
    end else if (step) begin
      shreg <= {shreg[WORD_W-2:0], 1'b0};
    end
  end

  // Retime onto the falling edge so the external chain sees the bit
  // settled around the rising edge that clocks it in.
  always_ff @(negedge clk) begin
    if (rst) begin
      ser_data <= 1'b0;
    end else begin
      ser_data <= shreg[WORD_W-1];
    end
  end
endmodule

// File: rtl/sr_dac_framer.sv
module sr_dac_framer
  import sr_dac_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = DEF_SAMPLE_W,
  parameter int unsigned NUM_CH       = DEF_NUM_CH,
  parameter int unsigned FRAME_CYCLES = DEF_FRAME_CYCLES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SAMPLE_W*NUM_CH-1:0] in_frame,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       ob_mode,
  output logic                       ser_data,
  output logic                       shift_en,
  output logic                       latch_stb,
  output logic                       underrun
);
  localparam int unsigned WORD_W = SAMPLE_W * NUM_CH;

  phase_t            phase;
  logic              start;
  logic [WORD_W-1:0] load_word;

  sr_dac_frame_timer #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .SHIFT_BITS  (WORD_W)
  ) timer_i (
    .clk  (clk),
    .rst  (rst),
    .phase(phase)
  );

  assign start    = (phase == PH_LOAD) && !rst;
  assign in_ready = start;

  sr_dac_frame_store #(
    .SAMPLE_W(SAMPLE_W),
    .NUM_CH  (NUM_CH)
  ) store_i (
    .clk      (clk),
    .rst      (rst),
    .take     (start),
    .in_valid (in_valid),
    .in_frame (in_frame),
    .ob_mode  (ob_mode),
    .load_word(load_word),
    .underrun (underrun)
  );

  sr_dac_shifter #(
    .WORD_W(WORD_W)
  ) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .step     (phase == PH_SHIFT),
    .load_word(load_word),
    .ser_data (ser_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_en  <= 1'b0;
      latch_stb <= 1'b0;
    end else begin
      shift_en  <= (phase == PH_LOAD) || (phase == PH_SHIFT);
      latch_stb <= (phase == PH_LATCH);
    end
  end
endmodule

// File: rtl/sr_dac_framer_chk.sv
module sr_dac_framer_chk #(
  parameter int unsigned FRAME_CYCLES = 256,
  parameter int unsigned SHIFT_BITS   = 32
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic shift_en,
  input logic latch_stb,
  input logic underrun
);
  localparam int unsigned GAP_W = $clog2(FRAME_CYCLES) + 1;
  localparam int unsigned SH_W  = $clog2(SHIFT_BITS) + 2;

  logic [GAP_W-1:0] gap;
  logic             seen_latch;
  logic [SH_W-1:0]  sh_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap        <= '0;
      seen_latch <= 1'b0;
      sh_cnt     <= '0;
    end else begin
      gap    <= latch_stb ? '0 : gap + 1'b1;
      sh_cnt <= latch_stb ? '0 : (shift_en ? sh_cnt + 1'b1 : sh_cnt);
      if (latch_stb) seen_latch <= 1'b1;
    end
  end

  AST_LATCH_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (latch_stb && seen_latch) |-> (gap == GAP_W'(FRAME_CYCLES - 1))); // R4

  AST_SHIFT_COUNT: assert property (@(posedge clk) disable iff (rst)
    latch_stb |-> (sh_cnt == SH_W'(SHIFT_BITS))); // R3

  AST_LATCH_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_en) |-> latch_stb); // R4

  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> !latch_stb); // R4

  AST_NO_SHIFT_AT_LATCH: assert property (@(posedge clk) disable iff (rst)
    !(shift_en && latch_stb)); // R4

  AST_READY_BEFORE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> (shift_en && !in_ready)); // R2

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun); // R7

  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!underrun && in_ready && !in_valid) |=> underrun); // R7

  AST_UNDERRUN_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    (!underrun && !(in_ready && !in_valid)) |=> !underrun); // R7
endmodule

bind sr_dac_framer sr_dac_framer_chk #(
  .FRAME_CYCLES(FRAME_CYCLES),
  .SHIFT_BITS  (SAMPLE_W * NUM_CH)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .shift_en (shift_en),
  .latch_stb(latch_stb),
  .underrun (underrun)
);

// File: tb/sr_dac_framer_tb_top.sv
`timescale 1ns/1ps
module sr_dac_framer_tb_top;
  localparam int FR = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_frame = '0;
  logic        in_valid = 1'b0;
  logic        ob_mode = 1'b0;
  logic        in_ready, ser_data, shift_en, latch_stb, underrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Schedule: frame offered at frame cycle 0, valid flag and mode
  logic [31:0] s_frame [9];
  bit          s_valid [9];
  bit          s_ob    [9];

  // Reference model state
  logic [31:0] ref_raw;
  logic [31:0] ref_word;
  bit          ref_under;

  always #10 clk = ~clk;

  sr_dac_framer dut_i (
    .clk(clk), .rst(rst), .in_frame(in_frame), .in_valid(in_valid),
    .in_ready(in_ready), .ob_mode(ob_mode), .ser_data(ser_data),
    .shift_en(shift_en), .latch_stb(latch_stb), .underrun(underrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] conv(input logic [31:0] w, input bit ob);
    return ob ? (w ^ 32'h8000_8000) : w;
  endfunction

  task automatic reset_phase();
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #16;
      chk("R1 shift_en in reset", {31'b0, shift_en}, 32'd0);
      chk("R1 latch_stb in reset", {31'b0, latch_stb}, 32'd0);
      chk("R1 in_ready in reset", {31'b0, in_ready}, 32'd0);
      chk("R1 underrun in reset", {31'b0, underrun}, 32'd0);
    end
    ref_raw   = '0;
    ref_word  = '0;
    ref_under = 1'b0;
  endtask

  task automatic run_frames(input int first, input int nfr);
    @(posedge clk); #2;
    rst = 1'b0;
    for (int k = 0; k < nfr * FR; k++) begin
      int m = k % FR;
      int n = first + k / FR;
      if (k != 0) begin
        @(posedge clk); #2;
      end
      if (m == 0) begin
        in_valid = s_valid[n];
        in_frame = s_frame[n];
        ob_mode  = s_ob[n];
      end else begin
        // Junk outside frame cycle 0 must be ignored (R6)
        in_valid = k[0];
        in_frame = 32'(k) * 32'h9E37_79B9;
        ob_mode  = !s_ob[n];
      end
      #14;
      chk("R2 in_ready", {31'b0, in_ready}, {31'b0, (m == 0)});
      chk("R3 shift_en", {31'b0, shift_en}, {31'b0, (m >= 1 && m <= 32)});
      chk("R4 latch_stb", {31'b0, latch_stb}, {31'b0, (m == 33)});
      chk("R7 underrun", {31'b0, underrun}, {31'b0, ref_under});
      if (m >= 1 && m <= 32) begin
        chk("R5 R6 R8 ser_data bit", {31'b0, ser_data}, {31'b0, ref_word[32 - m]});
      end
      if (m == 0) begin
        if (s_valid[n]) ref_raw = s_frame[n];
        else ref_under = 1'b1;
        ref_word = conv(ref_raw, s_ob[n]);
      end
    end
  endtask

  initial begin
    s_frame[0] = 32'hA5C3_1E70; s_valid[0] = 1; s_ob[0] = 0;
    s_frame[1] = 32'h8000_7FFF; s_valid[1] = 1; s_ob[1] = 1;
    s_frame[2] = 32'h1111_1111; s_valid[2] = 0; s_ob[2] = 0;
    s_frame[3] = 32'hFFFF_0001; s_valid[3] = 1; s_ob[3] = 1;
    s_frame[4] = 32'h0123_4567; s_valid[4] = 1; s_ob[4] = 0;
    s_frame[5] = 32'hDEAD_BEEF; s_valid[5] = 0; s_ob[5] = 1;
    s_frame[6] = 32'h7FFF_8000; s_valid[6] = 1; s_ob[6] = 0;
    // After a second reset: no frame offered, reset frame in offset mode (R1)
    s_frame[7] = 32'h5555_AAAA; s_valid[7] = 0; s_ob[7] = 1;
    s_frame[8] = 32'h5555_AAAA; s_valid[8] = 0; s_ob[8] = 0;

    reset_phase();
    run_frames(0, 7);
    reset_phase();
    run_frames(7, 2);
    // Latch strobe cycle 33 plus one more frame start seen: sanity on R4 after run
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule